// File: doc/BRIEF.md
# Buffered Input Capture Timer

The block is a free-running 16-bit timer with four input-capture channels. The counter advances once per tick of a programmable power-of-two prescaler. It stops advancing when the timer is disabled, when the stop input is high, or when the debug-freeze or wait input is high while the matching halt bit is set.

Each channel registers its input pin and passes it through a delay filter. The filter accepts a new level only after the pin has held that level for a chosen number of clock cycles. An accepted edge of the selected polarity copies the current counter value into the channel's capture register. At the same time the previous capture moves into a holding register, so two events are kept until software reads them. A per-channel flag marks each capture and is cleared by writing a one to it.

Software reaches the block through a simple word-wide register port. Writes take effect at the clock edge. Reads are combinational, so one read returns a whole, coherent 16-bit value.

Top module: `capture_timer_top`

## Requirements
- R1: The 16-bit counter resets to 0, adds exactly 1 on each prescaler tick, and wraps from 0xFFFF to 0x0000. It is read as one word at address 1, and writes to that address are ignored.
- R2: The control register at address 0 holds the prescale select in bits [6:4]. While the timer is running, a tick occurs once every 2^select clock cycles. Clearing the enable bit (bit 0) also clears the prescaler phase, so the first tick after re-enabling comes a full period later.
- R3: Counter and prescaler phase both hold under any of these conditions: enable bit 0 is clear; the stop input is high; the freeze input is high while bit 1 is set; the wait input is high while bit 2 is set. When freeze or wait is high with its halt bit clear, the counter keeps running.
- R4: The register map is: 0 control, 1 counter, 2 edge select, 3 filter select, 4 flags, 8 to 11 capture registers of channels 0 to 3, and 12 to 15 holding registers of channels 0 to 3. Reads of the control register return {enable, freeze-halt, wait-halt, 0, select} in bits 0, 1, 2, 3 and [6:4].
- R5: The filter select at address 3 holds 2 bits per channel, bits [2c+1:2c]. Code 00 turns the filter off. Codes 01, 10 and 11 require the registered pin to hold a new level for 256, 512 or 1024 consecutive cycles. A pulse of 255 cycles is rejected under code 01.
- R6: The edge select at address 2 holds 2 bits per channel, bits [2c+1:2c]. Code 00 captures nothing, 01 captures rising edges, 10 captures falling edges and 11 captures both. An accepted edge of a polarity that is not selected changes no register.
- R7: On a capture, the holding register takes the old capture value and the capture register takes the counter value of the cycle in which the filtered level changes. With the filter off, that cycle is the second clock edge after the pin changes.
- R8: Flag bit c at address 4 sets on each capture of channel c. Writing 1 to bit c clears it and writing 0 has no effect. A capture in the same cycle as the clearing write leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_i | input | 1 | Stop mode, halts counting |
| freeze_i | input | 1 | Debug freeze request |
| wait_i | input | 1 | Wait mode request |
| cap_pin_i | input | 4 | Capture input pins, one per channel |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Combinational read data for reg_addr_i |

## Verification
The hardest case to reach from the ports is a filter boundary, where the pin holds for exactly one cycle less than the delay and must be rejected. The neighbouring case, where the pin holds for the full delay, must be accepted with the counter value of an exact cycle. The bench drives pins at chosen falling edges for measured counts of 100, 255 and 300 cycles, with a 256-cycle filter. Its reference model counts the same cycles on its own. Counter wrap is reached by letting the divide-by-one timer run past 65536 cycles, with the counter compared against the model every cycle.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam logic [3:0] A_CTRL = 4'h0;
  localparam logic [3:0] A_COUNT = 4'h1;
  localparam logic [3:0] A_EDGE = 4'h2;
  localparam logic [3:0] A_FILT = 4'h3;
  localparam logic [3:0] A_FLAG = 4'h4;
  localparam int CAP_BASE = 8;
  localparam int HOLD_BASE = 12;

  // cycles per prescaler tick for a select code
  function automatic int unsigned div_ratio(input int unsigned sel);
    return 32'd1 << sel;
  endfunction

  // required stable cycles for a filter code (0 = filter off)
  function automatic int unsigned filter_cycles(input int unsigned sel, input int unsigned unit);
    if (sel == 0) return 0;
    return unit << (sel - 1);
  endfunction

  // polarity bit0 = rising, bit1 = falling
  function automatic logic edge_hit(input logic [1:0] pol, input logic prev, input logic nxt);
    return (pol[0] & nxt & ~prev) | (pol[1] & ~nxt & prev);
  endfunction
endpackage

// File: rtl/ct_timebase.sv
module ct_timebase #(
  parameter int CW = 16,
  parameter int PSW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          halt,
  input  logic [PSW-1:0] psel,
  output logic [CW-1:0] count,
  output logic          tick
);
  import ct_pkg::*;
  localparam int PW = (1 << PSW) - 1;

  logic [PW-1:0] pre_q;
  logic [PW-1:0] pre_lim;
  logic          run;

  assign run     = enable & ~halt;
  assign pre_lim = PW'(div_ratio(32'(psel)) - 1);
  assign tick    = run && (pre_q >= pre_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      count <= '0;
    end else if (!enable) begin
      pre_q <= '0;
    end else if (run) begin
      if (tick) begin
        pre_q <= '0;
        count <= count + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  // R1: counter moves only on a tick
  p_tick_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));
  // R1: wrap to zero
  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count == '1) |=> count == '0);
  // R3: halted timer never ticks and keeps its phase
  p_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && halt) |=> $stable(pre_q) && $stable(count));
  // R2: disable clears the phase
  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> pre_q == '0);
endmodule

// File: rtl/ct_filter.sv
module ct_filter #(
  parameter int UNIT = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] dsel,
  input  logic [1:0] pol,
  output logic       hit
);
  import ct_pkg::*;
  localparam int DW = $clog2(UNIT * 4 + 1);

  logic          s_q, f_q, f_nx;
  logic [DW-1:0] d_q, d_nx, limit;

  assign limit = DW'(filter_cycles(32'(dsel), UNIT));

  always_comb begin
    f_nx = f_q;
    d_nx = d_q;
    if (limit == '0) begin
      f_nx = s_q;
      d_nx = '0;
    end else if (s_q == f_q) begin
      d_nx = '0;
    end else if (d_q == limit - 1'b1) begin
      f_nx = s_q;
      d_nx = '0;
    end else begin
      d_nx = d_q + 1'b1;
    end
  end

  assign hit = edge_hit(pol, f_q, f_nx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q <= 1'b0;
      f_q <= 1'b0;
      d_q <= '0;
    end else begin
      s_q <= pin;
      f_q <= f_nx;
      d_q <= d_nx;
    end
  end

  // R5: a level not yet held long enough is not accepted
  p_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (limit != '0 && s_q != f_q && d_q != limit - 1'b1) |=> $stable(f_q));
  // R5: matching level resets the run length
  p_rerun_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s_q == f_q) |=> d_q == '0);
  // R6: no capture with no polarity selected
  p_pol_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> pol != 2'b00);
endmodule

// File: rtl/ct_capture.sv
module ct_capture #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic [CW-1:0] count,
  output logic [CW-1:0] cap,
  output logic [CW-1:0] hold
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap  <= '0;
      hold <= '0;
    end else if (hit) begin
      hold <= cap;
      cap  <= count;
    end
  end

  // R7: old capture shifts back, counter loads
  p_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (hold == $past(cap)) && (cap == $past(count)));
  // R6: no event, nothing changes
  p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(cap) && $stable(hold));
endmodule

// File: rtl/capture_timer_top.sv
module capture_timer_top #(
  parameter int CW = 16,
  parameter int NCH = 4,
  parameter int PSW = 3,
  parameter int FUNIT = 256
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           stop_i,
  input  logic           freeze_i,
  input  logic           wait_i,
  input  logic [NCH-1:0] cap_pin_i,
  input  logic           reg_wr_i,
  input  logic [3:0]     reg_addr_i,
  input  logic [CW-1:0]  reg_wdata_i,
  output logic [CW-1:0]  reg_rdata_o
);
  import ct_pkg::*;

  logic           en_q, fh_q, wh_q;
  logic [PSW-1:0] psel_q;
  logic [2*NCH-1:0] edge_q, filt_q;
  logic [NCH-1:0] flag_q, hits, clr;
  logic [CW-1:0]  count;
  logic           tick, halt;
  logic [CW-1:0]  cap  [NCH];
  logic [CW-1:0]  hold [NCH];

  assign halt = stop_i | (freeze_i & fh_q) | (wait_i & wh_q);

  ct_timebase #(.CW(CW), .PSW(PSW)) u_tb (
    .clk(clk), .rst_n(rst_n), .enable(en_q), .halt(halt),
    .psel(psel_q), .count(count), .tick(tick)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ct_filter #(.UNIT(FUNIT)) u_flt (
      .clk(clk), .rst_n(rst_n), .pin(cap_pin_i[c]),
      .dsel(filt_q[2*c+1:2*c]), .pol(edge_q[2*c+1:2*c]), .hit(hits[c])
    );
    ct_capture #(.CW(CW)) u_cap (
      .clk(clk), .rst_n(rst_n), .hit(hits[c]), .count(count),
      .cap(cap[c]), .hold(hold[c])
    );
  end

  assign clr = (reg_wr_i && reg_addr_i == A_FLAG) ? reg_wdata_i[NCH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      fh_q   <= 1'b0;
      wh_q   <= 1'b0;
      psel_q <= '0;
      edge_q <= '0;
      filt_q <= '0;
      flag_q <= '0;
    end else begin
      flag_q <= (flag_q & ~clr) | hits;
      if (reg_wr_i) begin
        case (reg_addr_i)
          A_CTRL: begin
            en_q   <= reg_wdata_i[0];
            fh_q   <= reg_wdata_i[1];
            wh_q   <= reg_wdata_i[2];
            psel_q <= reg_wdata_i[4 +: PSW];
          end
          A_EDGE:  edge_q <= reg_wdata_i[2*NCH-1:0];
          A_FILT:  filt_q <= reg_wdata_i[2*NCH-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL:  reg_rdata_o = CW'({psel_q, 1'b0, wh_q, fh_q, en_q});
      A_COUNT: reg_rdata_o = count;
      A_EDGE:  reg_rdata_o = CW'(edge_q);
      A_FILT:  reg_rdata_o = CW'(filt_q);
      A_FLAG:  reg_rdata_o = CW'(flag_q);
      default: begin
        for (int c = 0; c < NCH; c++) begin
          if (int'(reg_addr_i) == CAP_BASE + c)  reg_rdata_o = cap[c];
          if (int'(reg_addr_i) == HOLD_BASE + c) reg_rdata_o = hold[c];
        end
      end
    endcase
  end

  // R8: capture sets its flag, even against a clearing write
  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hits != '0) |=> ((flag_q & $past(hits)) == $past(hits)));
  // R8: written ones clear flags with no capture
  p_flag_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr != '0 && hits == '0) |=> ((flag_q & $past(clr)) == '0));
  // R8: no capture and no clear keeps flags
  p_flag_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr == '0 && hits == '0) |=> $stable(flag_q));
endmodule

// File: tb/capture_timer_top_test.sv
module capture_timer_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stop_i = 0, freeze_i = 0, wait_i = 0;
  logic [3:0]  cap_pin_i = 4'h0;
  logic        reg_wr_i = 0;
  logic [3:0]  reg_addr_i = 4'h1;
  logic [15:0] reg_wdata_i = 16'h0;
  logic [15:0] reg_rdata_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  capture_timer_top uut (
    .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .freeze_i(freeze_i),
    .wait_i(wait_i), .cap_pin_i(cap_pin_i), .reg_wr_i(reg_wr_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o)
  );

  // reference model state
  int m_cnt, m_pre, m_en, m_fh, m_wh, m_psel, m_edge, m_filt, m_flag;
  int m_s[4], m_f[4], m_run[4], m_cap[4], m_hold[4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_en = 0; m_fh = 0; m_wh = 0; m_psel = 0;
      m_edge = 0; m_filt = 0; m_flag = 0;
      for (int c = 0; c < 4; c++) begin
        m_s[c] = 0; m_f[c] = 0; m_run[c] = 0; m_cap[c] = 0; m_hold[c] = 0;
      end
    end else begin
      int need, nf, pol, setm, period;
      bit going;
      setm = 0;
      for (int c = 0; c < 4; c++) begin
        need = ((m_filt >> (2*c)) & 3) == 0 ? 0 : 128 * (1 << ((m_filt >> (2*c)) & 3));
        pol = (m_edge >> (2*c)) & 3;
        nf = m_f[c];
        if (need == 0) begin nf = m_s[c]; m_run[c] = 0; end
        else if (m_s[c] == m_f[c]) m_run[c] = 0;
        else if (m_run[c] + 1 >= need) begin nf = m_s[c]; m_run[c] = 0; end
        else m_run[c]++;
        if ((nf == 1 && m_f[c] == 0 && (pol & 1)) || (nf == 0 && m_f[c] == 1 && (pol & 2))) begin
          m_hold[c] = m_cap[c];
          m_cap[c] = m_cnt;
          setm |= (1 << c);
        end
        m_f[c] = nf;
        m_s[c] = cap_pin_i[c];
      end
      if (reg_wr_i && reg_addr_i == 4) m_flag &= ~int'(reg_wdata_i[3:0]);
      m_flag |= setm;
      going = m_en && !stop_i && !(freeze_i && m_fh) && !(wait_i && m_wh);
      period = 1 << m_psel;
      if (!m_en) m_pre = 0;
      else if (going) begin
        m_pre++;
        if (m_pre >= period) begin m_pre = 0; m_cnt = (m_cnt + 1) % 65536; end
      end
      if (reg_wr_i) begin
        if (reg_addr_i == 0) begin
          m_en = reg_wdata_i[0]; m_fh = reg_wdata_i[1]; m_wh = reg_wdata_i[2];
          m_psel = reg_wdata_i[6:4];
        end
        if (reg_addr_i == 2) m_edge = reg_wdata_i[7:0];
        if (reg_addr_i == 3) m_filt = reg_wdata_i[7:0];
      end
    end
  end

  function automatic int model_read(int a);
    if (a == 0) return m_en + 2*m_fh + 4*m_wh + 16*m_psel;
    if (a == 1) return m_cnt;
    if (a == 2) return m_edge;
    if (a == 3) return m_filt;
    if (a == 4) return m_flag;
    if (a >= 8 && a < 12) return m_cap[a-8];
    if (a >= 12) return m_hold[a-12];
    return 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // every idle clock compares the counter word
  task automatic idle(input int n, input string req);
    repeat (n) begin
      @(negedge clk);
      reg_addr_i = 4'h1;
      #1 chk(req, reg_rdata_o, model_read(1));
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr_i = 1; reg_addr_i = 4'(a); reg_wdata_i = 16'(d);
    @(negedge clk);
    reg_wr_i = 0; reg_addr_i = 4'h1;
  endtask

  task automatic rd(input int a, input string req);
    reg_addr_i = 4'(a);
    #1 chk(req, reg_rdata_o, model_read(a));
    reg_addr_i = 4'h1;
  endtask

  task automatic pin(input int c, input bit v);
    @(negedge clk);
    cap_pin_i[c] = v;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 180000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R4 reset state
    reg_addr_i = 0; #1 chk("R4 ctrl reset", reg_rdata_o, 0);
    reg_addr_i = 1; #1 chk("R1 counter reset", reg_rdata_o, 0);
    reg_addr_i = 4; #1 chk("R8 flags reset", reg_rdata_o, 0);
    idle(5, "R3 disabled hold");
    wr(0, 16'h01);
    rd(0, "R4 ctrl readback");
    idle(20, "R1 divide by one");
    wr(1, 16'h1234);
    idle(3, "R1 counter write ignored");
    wr(0, 16'h31);
    idle(40, "R2 divide by eight");
    stop_i = 1; idle(12, "R3 stop"); stop_i = 0;
    freeze_i = 1; idle(10, "R3 freeze without halt bit");
    wr(0, 16'h33); idle(12, "R3 freeze halt"); freeze_i = 0;
    idle(10, "R3 freeze released");
    wr(0, 16'h35); wait_i = 1; idle(12, "R3 wait halt"); wait_i = 0;
    wr(0, 16'h30); idle(5, "R2 disabled");
    wr(0, 16'h31); idle(20, "R2 phase cleared");
    wr(0, 16'h01);
    idle(65600, "R1 wrap");
    // edges: ch0 rise, ch1 rise, ch2 both, ch3 fall
    wr(2, 16'hB5);
    rd(2, "R6 edge readback");
    pin(0, 1); idle(3, "R7 ch0"); pin(0, 0); idle(4, "R7 ch0");
    rd(8, "R7 first capture ch0");
    rd(4, "R8 flag set ch0");
    pin(0, 1); idle(6, "R7 ch0"); pin(0, 0); idle(4, "R7 ch0");
    rd(8, "R7 second capture ch0");
    rd(12, "R7 holding ch0");
    wr(4, 16'h0); rd(4, "R8 write zero no effect");
    pin(1, 1); idle(4, "R6 ch1");
    rd(9, "R6 ch1 rising captured");
    wr(4, 16'hF); rd(4, "R8 write one clears");
    pin(1, 0); idle(5, "R6 ch1");
    rd(9, "R6 ch1 falling ignored");
    rd(13, "R6 ch1 holding unchanged");
    rd(4, "R6 ch1 no flag");
    pin(3, 1); idle(4, "R6 ch3"); rd(4, "R6 ch3 rising ignored");
    pin(3, 0); idle(4, "R6 ch3"); rd(11, "R6 ch3 falling captured");
    rd(4, "R8 ch3 flag");
    wr(4, 16'hF);
    // filter 256 on ch2
    wr(3, 16'h10);
    pin(2, 1); idle(99, "R5 ch2"); pin(2, 0); idle(300, "R5 ch2");
    rd(4, "R5 100 cycle pulse rejected");
    rd(10, "R5 capture untouched");
    pin(2, 1); idle(299, "R5 ch2"); pin(2, 0); idle(10, "R5 ch2");
    rd(10, "R5 accepted rise");
    rd(4, "R5 flag after rise");
    pin(2, 1); idle(10, "R5 ch2"); wr(4, 16'hF);
    pin(2, 0); idle(254, "R5 ch2"); pin(2, 1); idle(300, "R5 ch2");
    rd(4, "R5 255 cycle low rejected");
    rd(14, "R5 holding ch2");
    pin(2, 0); idle(300, "R5 ch2");
    rd(10, "R5 accepted fall");
    rd(14, "R7 holding after fall");
    finish_run();
  end
endmodule